// File: doc/BRIEF.md
# Scatter-Gather Link List Walker

This block follows a chain of link entries held in memory for one data direction of a serial transfer. Each entry is 8 bytes. The first 32-bit word holds control bits and the segment length. The second word holds the 32-bit start address of the segment. For each usable entry the walker hands a segment command (address, length, interrupt request, action code) to a byte mover. The walk therefore covers memory regions that are not contiguous while the serial transfer continues as one stream.

A start pulse loads the list base address. The walker then reads each entry with a simple request/response handshake. It moves on to the next entry only after the mover reports that the current segment is finished. The walk stops in one of two ways. It finishes at an entry that marks the end of the list, or it aborts on an entry that is not usable. A sticky flag records which of the two happened. An end entry that also has the ring bit set sends the walker back to the list base instead of stopping.

Top module: `sg_link_walker`

## Requirements
- R1: While reset is asserted and after it is released, memReqValid, segValid, busy, walkDone and walkInvalid are all 0 until a start pulse arrives.
- R2: A start pulse while idle reads the entry at listBase in two requests. The first request is at the entry address and fetches the control word. The second is at entry address + 4 and fetches the segment address word.
- R3: Control word fields are: bit 0 valid, bit 1 end of list, bit 2 interrupt request, bits [5:3] action code, bit 6 ring, bits [31:8] segment length in bytes. The segment command carries segAddr = second word, segLen = bits [31:8], segIrq = bit 2 and segAction = bits [5:3].
- R4: segValid rises only after both words of the entry have been received. It stays high with segAddr and segLen unchanged until segReady is seen.
- R5: No memory request is made between acceptance of a segment command and the segDone pulse. After segDone on an entry that is not an end entry, the next entry is read at the current entry address + 8.
- R6: When the segment of an entry with the end bit set and the ring bit clear completes, the walker sets walkDone and returns to idle (busy = 0).
- R7: An entry with its valid bit clear issues no segment command. It sets walkInvalid and returns the walker to idle. walkDone and walkInvalid are never both set.
- R8: An entry whose length is above 2^20 bytes is handled like an invalid entry. A length of exactly 2^20 is accepted.
- R9: When the segment of an entry with both the end bit and the ring bit set completes, the next entry is read at the list base address and the walk continues.
- R10: A start pulse while busy is ignored. The walk in progress keeps its base and position.
- R11: A start pulse accepted while idle clears walkDone and walkInvalid.
- R12: memReqValid stays high with memReqAddr unchanged until memReqReady is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a walk at listBase (ignored while busy) |
| listBase | input | ADDR_W | Byte address of the first entry |
| memReqValid | output | 1 | Entry word read request |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Byte address of the word to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data word |
| segValid | output | 1 | Segment command valid |
| segReady | input | 1 | Mover accepts the segment command |
| segAddr | output | 32 | Segment start address |
| segLen | output | 24 | Segment length in bytes |
| segIrq | output | 1 | Entry requests an interrupt |
| segAction | output | 3 | Entry action code |
| segDone | input | 1 | Mover finished the current segment |
| busy | output | 1 | Walk in progress |
| walkDone | output | 1 | Sticky: walk ended at an end entry |
| walkInvalid | output | 1 | Sticky: walk aborted on an unusable entry |

## Verification
The hardest case to reach from the ports is the ring return. The walker only goes back to the base after a full pass over a list whose last entry has both the end and ring bits set. A start pulse that arrives while it circles must leave the base untouched. The bench builds a two-entry ring in its memory model and waits for the third segment command, which must repeat the first entry's address. During the second pass it fires a start pulse aimed at a different list and checks that the fourth segment still belongs to the ring. The memory model also counts any read request made while a segment is open, which exposes an early fetch.

// File: rtl/sg_walk_pkg.sv
package sg_walk_pkg;

  localparam int WORD_W      = 32;
  localparam int LEN_W       = 24;
  localparam int ACT_W       = 3;
  localparam int WORD_BYTES  = 4;
  localparam int ENTRY_BYTES = 2 * WORD_BYTES;

  // control word bit positions
  localparam int VALID_POS = 0;
  localparam int END_POS   = 1;
  localparam int IRQ_POS   = 2;
  localparam int ACT_LSB   = 3;
  localparam int RING_POS  = 6;
  localparam int LEN_LSB   = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_CTRL,
    ST_WAIT_CTRL,
    ST_REQ_PTR,
    ST_WAIT_PTR,
    ST_CHECK,
    ST_ISSUE,
    ST_RUN
  } walkState_t;

  typedef struct packed {
    logic loadBase;
    logic ptrWord;
    logic capCtrl;
    logic capPtr;
    logic stepNext;
    logic rewind;
    logic setDone;
    logic setInvalid;
  } dpStrobe_t;

  typedef struct packed {
    logic             valid;
    logic             endList;
    logic             irq;
    logic [ACT_W-1:0] action;
    logic             ring;
    logic [LEN_W-1:0] len;
  } linkCtrl_t;

  function automatic linkCtrl_t decodeLink(input logic [WORD_W-1:0] w);
    linkCtrl_t c;
    c.valid   = w[VALID_POS];
    c.endList = w[END_POS];
    c.irq     = w[IRQ_POS];
    c.action  = w[ACT_LSB +: ACT_W];
    c.ring    = w[RING_POS];
    c.len     = w[LEN_LSB +: LEN_W];
    return c;
  endfunction

endpackage

// File: rtl/sg_walk_dp.sv
module sg_walk_dp
  import sg_walk_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MAX_SEG_LEN = 1 << 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] listBase,
  input  logic [WORD_W-1:0] rspData,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [WORD_W-1:0] segAddr,
  output logic [LEN_W-1:0]  segLen,
  output logic              segIrq,
  output logic [ACT_W-1:0]  segAction,
  output logic              entryOk,
  output logic              entryEnd,
  output logic              entryRing,
  output logic              doneFlag,
  output logic              invalidFlag
);

  localparam logic [LEN_W-1:0]  MaxLen   = LEN_W'(MAX_SEG_LEN);
  localparam logic [ADDR_W-1:0] PtrOfs   = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] EntryOfs = ADDR_W'(ENTRY_BYTES);

  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] entryAddr;
  linkCtrl_t         ctrlReg;
  logic [WORD_W-1:0] ptrReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr    <= '0;
      entryAddr   <= '0;
      ctrlReg     <= '0;
      ptrReg      <= '0;
      doneFlag    <= 1'b0;
      invalidFlag <= 1'b0;
    end else begin
      if (strb.loadBase) begin
        baseAddr    <= listBase;
        entryAddr   <= listBase;
        doneFlag    <= 1'b0;
        invalidFlag <= 1'b0;
      end
      if (strb.capCtrl)    ctrlReg     <= decodeLink(rspData);
      if (strb.capPtr)     ptrReg      <= rspData;
      if (strb.stepNext)   entryAddr   <= entryAddr + EntryOfs;
      if (strb.rewind)     entryAddr   <= baseAddr;
      if (strb.setDone)    doneFlag    <= 1'b1;
      if (strb.setInvalid) invalidFlag <= 1'b1;
    end
  end

  assign reqAddr   = strb.ptrWord ? entryAddr + PtrOfs : entryAddr;
  assign segAddr   = ptrReg;
  assign segLen    = ctrlReg.len;
  assign segIrq    = ctrlReg.irq;
  assign segAction = ctrlReg.action;
  assign entryOk   = ctrlReg.valid && (ctrlReg.len <= MaxLen);
  assign entryEnd  = ctrlReg.endList;
  assign entryRing = ctrlReg.ring;

  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(doneFlag && invalidFlag));

  // R11
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadBase |=> !doneFlag && !invalidFlag);

endmodule

// File: rtl/sg_walk_ctrl.sv
module sg_walk_ctrl
  import sg_walk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      memReqReady,
  input  logic      memRspValid,
  input  logic      segReady,
  input  logic      segDone,
  input  logic      entryOk,
  input  logic      entryEnd,
  input  logic      entryRing,
  output dpStrobe_t strb,
  output logic      memReqValid,
  output logic      segValid,
  output logic      busy
);

  walkState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    strb        = '0;
    memReqValid = 1'b0;
    segValid    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strb.loadBase = 1'b1;
          nextState     = ST_REQ_CTRL;
        end
      end
      ST_REQ_CTRL: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = ST_WAIT_CTRL;
      end
      ST_WAIT_CTRL: begin
        if (memRspValid) begin
          strb.capCtrl = 1'b1;
          nextState    = ST_REQ_PTR;
        end
      end
      ST_REQ_PTR: begin
        memReqValid  = 1'b1;
        strb.ptrWord = 1'b1;
        if (memReqReady) nextState = ST_WAIT_PTR;
      end
      ST_WAIT_PTR: begin
        if (memRspValid) begin
          strb.capPtr = 1'b1;
          nextState   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!entryOk) begin
          strb.setInvalid = 1'b1;
          nextState       = ST_IDLE;
        end else begin
          nextState = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        segValid = 1'b1;
        if (segReady) nextState = ST_RUN;
      end
      ST_RUN: begin
        if (segDone) begin
          if (entryEnd && entryRing) begin
            strb.rewind = 1'b1;
            nextState   = ST_REQ_CTRL;
          end else if (entryEnd) begin
            strb.setDone = 1'b1;
            nextState    = ST_IDLE;
          end else begin
            strb.stepNext = 1'b1;
            nextState     = ST_REQ_CTRL;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);

  // R4
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    segValid && !segReady |=> segValid);

  // R5
  req_seg_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memReqValid, segValid}));

  // R10
  start_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startPulse));

endmodule

// File: rtl/sg_link_walker.sv
module sg_link_walker
  import sg_walk_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MAX_SEG_LEN = 1 << 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [ADDR_W-1:0] listBase,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData,
  output logic              segValid,
  input  logic              segReady,
  output logic [31:0]       segAddr,
  output logic [23:0]       segLen,
  output logic              segIrq,
  output logic [2:0]        segAction,
  input  logic              segDone,
  output logic              busy,
  output logic              walkDone,
  output logic              walkInvalid
);

  dpStrobe_t strb;
  logic      entryOk;
  logic      entryEnd;
  logic      entryRing;

  sg_walk_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .segReady    (segReady),
    .segDone     (segDone),
    .entryOk     (entryOk),
    .entryEnd    (entryEnd),
    .entryRing   (entryRing),
    .strb        (strb),
    .memReqValid (memReqValid),
    .segValid    (segValid),
    .busy        (busy)
  );

  sg_walk_dp #(
    .ADDR_W      (ADDR_W),
    .MAX_SEG_LEN (MAX_SEG_LEN)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .listBase    (listBase),
    .rspData     (memRspData),
    .reqAddr     (memReqAddr),
    .segAddr     (segAddr),
    .segLen      (segLen),
    .segIrq      (segIrq),
    .segAction   (segAction),
    .entryOk     (entryOk),
    .entryEnd    (entryEnd),
    .entryRing   (entryRing),
    .doneFlag    (walkDone),
    .invalidFlag (walkInvalid)
  );

  // R4
  seg_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    segValid && !segReady |=> $stable(segAddr) && $stable(segLen));

  // R8
  len_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    segValid |-> ({8'd0, segLen} <= 32'(MAX_SEG_LEN)));

  // R12
  req_addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr));

endmodule

// File: tb/test_sg_link_walker.sv
`timescale 1ns/1ps
module test_sg_link_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [31:0] listBase = '0;
  logic        memReqValid;
  logic        memReqReady;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        segValid;
  logic        segReady;
  logic [31:0] segAddr;
  logic [23:0] segLen;
  logic        segIrq;
  logic [2:0]  segAction;
  logic        segDone = 1'b0;
  logic        busy;
  logic        walkDone;
  logic        walkInvalid;

  logic memReadyHold = 1'b1;
  logic segReadyHold = 1'b1;
  logic clrLogs = 1'b0;
  assign memReqReady = memReadyHold;
  assign segReady    = segReadyHold;

  always #2.5 clk = ~clk;

  sg_link_walker i_sg_link_walker (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .listBase(listBase),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .segValid(segValid), .segReady(segReady), .segAddr(segAddr), .segLen(segLen),
    .segIrq(segIrq), .segAction(segAction), .segDone(segDone),
    .busy(busy), .walkDone(walkDone), .walkInvalid(walkInvalid)
  );

  // memory and mover models
  logic [31:0] mem [0:63];
  logic        pend = 1'b0;
  logic [5:0]  pendIdx = '0;
  int          doneCnt = 0;
  int          segCount = 0;
  int          reqCount = 0;
  int          orderErr = 0;
  logic        segOpen = 1'b0;
  logic [31:0] reqLog [0:31];
  logic [31:0] segAddrLog [0:15];
  logic [23:0] segLenLog [0:15];
  logic        segIrqLog [0:15];
  logic [2:0]  segActLog [0:15];

  always @(negedge clk) begin
    memRspValid <= pend;
    memRspData  <= mem[pendIdx];
    pend        <= memReqValid && memReqReady;
    pendIdx     <= memReqAddr[7:2];
    segDone     <= (doneCnt == 1);
    if (doneCnt != 0) doneCnt <= doneCnt - 1;
    if (clrLogs) begin
      segCount <= 0;
      reqCount <= 0;
      orderErr <= 0;
      segOpen  <= 1'b0;
    end else begin
      if (memReqValid && memReqReady) begin
        if (reqCount < 32) reqLog[reqCount] <= memReqAddr;
        reqCount <= reqCount + 1;
        if (segOpen) orderErr <= orderErr + 1;
      end
      if (segValid && segReady) begin
        if (segCount < 16) begin
          segAddrLog[segCount] <= segAddr;
          segLenLog[segCount]  <= segLen;
          segIrqLog[segCount]  <= segIrq;
          segActLog[segCount]  <= segAction;
        end
        segCount <= segCount + 1;
        doneCnt  <= 3;
        segOpen  <= 1'b1;
      end
      if (doneCnt == 1) segOpen <= 1'b0;
    end
  end

  int errors = 0;
  int checks = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic clearLogs();
    @(negedge clk);
    clrLogs = 1'b1;
    @(negedge clk);
    clrLogs = 1'b0;
  endtask

  task automatic startWalk(input logic [31:0] b);
    @(negedge clk);
    listBase   = b;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk("idle-timeout", {31'd0, busy}, 32'd0);
  endtask

  task automatic waitSegs(input int target);
    int n = 0;
    while (segCount < target && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] ptr;
    logic        expSeg;
    logic        expDone;
    logic        expInv;
  } vec_t;

  // single-entry lists at base 0x20; the word pair after it is zero
  localparam vec_t VECS [0:5] = '{
    '{32'h0000_1003, 32'h8000_0000, 1'b1, 1'b1, 1'b0}, // plain end entry
    '{32'h0001_002F, 32'h1234_5678, 1'b1, 1'b1, 1'b0}, // irq, action 5
    '{32'h0000_1002, 32'h9000_0000, 1'b0, 1'b0, 1'b1}, // valid clear
    '{32'h1000_0003, 32'h7000_0000, 1'b1, 1'b1, 1'b0}, // length exactly 2^20
    '{32'h1000_0103, 32'h7100_0000, 1'b0, 1'b0, 1'b1}, // length 2^20+1
    '{32'h0000_0801, 32'h6000_0000, 1'b1, 1'b0, 1'b1}  // not end, next entry empty
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    logic [31:0] held;
    for (int i = 0; i < 64; i++) mem[i] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reqValid in reset", {31'd0, memReqValid}, 32'd0);
    chk("R1 segValid in reset", {31'd0, segValid}, 32'd0);
    chk("R1 flags in reset", {29'd0, busy, walkDone, walkInvalid}, 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", {28'd0, memReqValid, segValid, busy, walkDone | walkInvalid}, 32'd0);

    // R3 R6 R7 R8: vector table
    for (int v = 0; v < 6; v++) begin
      mem[8]  = VECS[v].ctrl;
      mem[9]  = VECS[v].ptr;
      mem[10] = '0;
      mem[11] = '0;
      clearLogs();
      startWalk(32'h20);
      waitIdle();
      chk($sformatf("R7 v%0d segment count", v), segCount, {31'd0, VECS[v].expSeg});
      chk($sformatf("R6 v%0d walkDone", v), {31'd0, walkDone}, {31'd0, VECS[v].expDone});
      chk($sformatf("R8 v%0d walkInvalid", v), {31'd0, walkInvalid}, {31'd0, VECS[v].expInv});
      if (VECS[v].expSeg) begin
        chk($sformatf("R3 v%0d segAddr", v), segAddrLog[0], VECS[v].ptr);
        chk($sformatf("R3 v%0d segLen", v), {8'd0, segLenLog[0]}, {8'd0, VECS[v].ctrl[31:8]});
        chk($sformatf("R3 v%0d segIrq", v), {31'd0, segIrqLog[0]}, {31'd0, VECS[v].ctrl[2]});
        chk($sformatf("R3 v%0d segAction", v), {29'd0, segActLog[0]}, {29'd0, VECS[v].ctrl[5:3]});
      end
    end

    // R2 R5 R11: three-entry chain at base 0
    mem[0] = 32'h0000_2001; mem[1] = 32'hC000_0000;
    mem[2] = 32'h0000_3001; mem[3] = 32'hC100_0000;
    mem[4] = 32'h0000_4003; mem[5] = 32'hC200_0000;
    clearLogs();
    startWalk(32'h0);
    chk("R11 invalid cleared by start", {31'd0, walkInvalid}, 32'd0);
    waitIdle();
    chk("R2 first request addr", reqLog[0], 32'h0);
    chk("R2 second request addr", reqLog[1], 32'h4);
    chk("R5 next entry addr", reqLog[2], 32'h8);
    chk("R5 request count", reqCount, 32'd6);
    chk("R5 no fetch while segment open", orderErr, 32'd0);
    chk("R5 seg order 0", segAddrLog[0], 32'hC000_0000);
    chk("R5 seg order 1", segAddrLog[1], 32'hC100_0000);
    chk("R5 seg order 2", segAddrLog[2], 32'hC200_0000);
    chk("R6 chain done", {30'd0, walkDone, walkInvalid}, 32'd2);

    // R9 R10: ring list at base 0x60
    mem[24] = 32'h0000_0401; mem[25] = 32'hA000_0000;
    mem[26] = 32'h0000_0843; mem[27] = 32'hB000_0000;
    clearLogs();
    startWalk(32'h60);
    waitSegs(3);
    chk("R9 ring returns to base", segAddrLog[2], 32'hA000_0000);
    chk("R9 still busy, not done", {30'd0, busy, walkDone}, 32'd2);
    startWalk(32'h0);
    waitSegs(4);
    chk("R10 start ignored while busy", segAddrLog[3], 32'hB000_0000);
    chk("R5 ring no fetch while open", orderErr, 32'd0);

    // R1: reset mid-walk
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-walk", {27'd0, memReqValid, segValid, busy, walkDone, walkInvalid}, 32'd0);
    rstN = 1'b1;

    // R12: memory back-pressure
    mem[8] = 32'h0000_1003; mem[9] = 32'h5500_0000;
    memReadyHold = 1'b0;
    clearLogs();
    startWalk(32'h20);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R12 request held", {31'd0, memReqValid}, 32'd1);
      chk("R12 address held", memReqAddr, 32'h20);
    end
    memReadyHold = 1'b1;
    waitIdle();
    chk("R12 completes after stall", {31'd0, walkDone}, 32'd1);

    // R4: mover back-pressure
    segReadyHold = 1'b0;
    clearLogs();
    startWalk(32'h20);
    begin
      int n = 0;
      while (!segValid && n < 100) begin
        @(negedge clk);
        n++;
      end
    end
    chk("R4 segment after both words", reqCount, 32'd2);
    held = segAddr;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R4 segValid held", {31'd0, segValid}, 32'd1);
      chk("R4 segAddr held", segAddr, held);
    end
    segReadyHold = 1'b1;
    waitIdle();
    chk("R4 segment accepted once", segCount, 32'd1);

    finishRun();
  end

endmodule